// File: doc/BRIEF.md
# Serial Result Shifter for a Sampling Converter

This block is the digital output half of a sampling converter. An active-low start line marks each sample instant, and an external serial clock then moves the result out. A falling edge on the start line captures a 12-bit two's complement sample from a parallel port. That port stands in for the analog core. The block then sends a 16-bit frame on a serial data line that has a separate output-enable, which models a tri-state pin.

The block runs from a faster system clock. Two-flop synchronizers bring the serial clock and the start line into that clock domain, and edge detectors turn their transitions into single-cycle events. The serial clock may idle high or low. Data moves only on serial-clock rising edges.

When a frame ends, the block does one of three things, depending on the start line:
- **Bus release:** the start line is low at the 16th falling edge, so the enable drops at the next rising edge of either input. This lets several converters share one line.
- **Chaining:** the start line went high after the 14th rising edge and before the 16th, so the line stays driven and the next frame can begin back to back.
- **Immediate drop:** otherwise the enable drops at the 16th falling edge.

Top module: `conv_result_shifter`

## Requirements
- R1: After reset the output-enable `sdata_oe` is 0 and `sdata_out` is 0.
- R2: A falling edge on `conv_start_n` while no frame is in progress starts a frame, whatever the idle level of `sclk_in`. It sets `sdata_oe` to 1 and drives `sdata_out` to 0.
- R3: The frame is 16 bits: three 0 bits, then the 12 sample bits with the most significant first, then one 0 bit. The first 0 appears at the start. After rising edge k of `sclk_in` (k = 1..15), the line carries frame bit 15-k, where bit 15 is the first bit sent. After the 16th rising edge it carries 0. `sdata_out` changes on no other event.
- R4: The sample on `sample_in` is captured at the start edge. Later changes to `sample_in` do not alter the frame in progress.
- R5: The sample is sent as two's complement without change. 12'h7FF (most positive) is sent as 0111_1111_1111, and 12'h800 (most negative) is sent as 1000_0000_0000.
- R6: If `conv_start_n` is low at the 16th falling edge of `sclk_in`, `sdata_oe` stays 1 until the next rising edge of `sclk_in`, and then drops to 0.
- R7: In the same waiting state, a rising edge on `conv_start_n` that falls outside the chaining window also drops `sdata_oe` to 0.
- R8: A rising edge on `conv_start_n` after the 14th rising edge of `sclk_in` and before the 16th keeps `sdata_oe` at 1, with `sdata_out` at 0, after the frame ends. The next falling edge on `conv_start_n` then starts a fresh frame with a newly captured sample.
- R9: A falling edge on `conv_start_n` during a frame, with no chaining window opened, is ignored. The frame in progress continues with its original sample.
- R10: When a chaining rising edge of `conv_start_n` lands in the same system-clock cycle as the `sclk_in` rising edge that would release the line, chaining wins and `sdata_oe` stays 1.
- R11: If `conv_start_n` is high at the 16th falling edge and no chaining window was opened, `sdata_oe` drops to 0 at that falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | External serial clock, asynchronous to `clk` |
| conv_start_n | input | 1 | Active-low conversion start, asynchronous to `clk` |
| sample_in | input | 12 | Two's complement sample from the converter core |
| sdata_out | output | 1 | Serial data value |
| sdata_oe | output | 1 | Drive enable for the serial data line (0 means high impedance) |

## Verification
Two events can land in the same system-clock cycle:
- a rising edge of the serial clock that would release a waiting line;
- a rising edge of the start line that opens the chaining window.

Both inputs pass through identical synchronizers. The bench therefore runs a frame with the serial clock idling high, and moves both inputs high in the same step right after the 16th falling edge. It expects the line to stay driven low, and then expects a clean frame from the next start edge.

The same idle-high run also shows the usual case: when only the serial clock rises, the line is released.

// File: rtl/conv_shift_pkg.sv
`timescale 1ns/1ps
package conv_shift_pkg;

  // Index of the start line and the serial clock in the synchronized bus.
  localparam int SCLK_IDX  = 0;
  localparam int START_IDX = 1;

  // True once the 14th rising edge has passed and the 16th has not.
  function automatic logic in_chain_window(input int unsigned rises,
                                           input int unsigned frame_len);
    return (rises >= frame_len - 2) && (rises < frame_len);
  endfunction

  // Number of frame bits the sample is packed into.
  function automatic int unsigned frame_len(input int unsigned lead,
                                            input int unsigned data,
                                            input int unsigned trail);
    return lead + data + trail;
  endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
  parameter int            W       = 2,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cs_edge.sv
`timescale 1ns/1ps
module cs_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/cs_frame_ctrl.sv
`timescale 1ns/1ps
module cs_frame_ctrl
  import conv_shift_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int LEAD_Z  = 3,
  parameter int TRAIL_Z = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_lvl,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              start_rise,
  input  logic              start_fall,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              oe,
  output logic              ev_start,
  output logic              ev_release,
  output logic              ev_chain,
  output logic              in_frame,
  output logic              rel_wait
);
  localparam int FRAME_W = frame_len(LEAD_Z, DATA_W, TRAIL_Z);
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   rise_cnt, fall_cnt;
  logic               in_frame_q, chain_q, rel_wait_q, oe_q, dout_q;
  logic               win, last_fall;
  logic [FRAME_W-1:0] new_frame;

  assign new_frame = {{LEAD_Z{1'b0}}, sample, {TRAIL_Z{1'b0}}};

  // Events of this cycle, decided from registered state.
  assign ev_start   = start_fall && (!in_frame_q || chain_q);
  assign win        = in_chain_window(int'(rise_cnt), FRAME_W) && (in_frame_q || rel_wait_q);
  assign ev_chain   = start_rise && win && !ev_start;
  assign last_fall  = in_frame_q && sclk_fall && (fall_cnt == LAST - 1'b1);
  assign ev_release = !ev_start && !ev_chain &&
                      ((rel_wait_q && (sclk_rise || start_rise)) ||
                       (last_fall && start_lvl && !chain_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      rise_cnt   <= LAST;
      fall_cnt   <= '0;
      in_frame_q <= 1'b0;
      chain_q    <= 1'b0;
      rel_wait_q <= 1'b0;
      oe_q       <= 1'b0;
      dout_q     <= 1'b0;
    end else if (ev_start) begin
      shreg      <= new_frame;
      dout_q     <= new_frame[FRAME_W-1];
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      in_frame_q <= 1'b1;
      chain_q    <= 1'b0;
      rel_wait_q <= 1'b0;
      oe_q       <= 1'b1;
    end else begin
      if (sclk_rise && rise_cnt < LAST) begin
        rise_cnt <= rise_cnt + 1'b1;
        if (in_frame_q) begin
          shreg  <= {shreg[FRAME_W-2:0], 1'b0};
          dout_q <= shreg[FRAME_W-2];
        end
      end
      if (sclk_fall && in_frame_q) begin
        fall_cnt <= fall_cnt + 1'b1;
        if (last_fall) begin
          in_frame_q <= 1'b0;
          rel_wait_q <= !start_lvl;
        end
      end
      if (ev_chain) begin
        chain_q    <= 1'b1;
        rel_wait_q <= 1'b0;
      end
      if (ev_release) begin
        oe_q       <= 1'b0;
        rel_wait_q <= 1'b0;
        chain_q    <= 1'b0;
      end
    end
  end

  assign dout     = dout_q;
  assign oe       = oe_q;
  assign in_frame = in_frame_q;
  assign rel_wait = rel_wait_q;
endmodule

// File: rtl/conv_result_shifter.sv
`timescale 1ns/1ps
module conv_result_shifter
  import conv_shift_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_Z      = 3,
  parameter int TRAIL_Z     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              conv_start_n,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata_out,
  output logic              sdata_oe
);
  localparam int          NSIG    = 2;
  localparam logic [NSIG-1:0] IDLE_LVL = NSIG'(1) << START_IDX;

  logic [NSIG-1:0] raw_in, lvl, rise, fall;
  logic sclk_rise, sclk_fall, start_rise, start_fall, start_lvl;
  logic ev_start, ev_release, ev_chain, in_frame, rel_wait;

  always_comb begin
    raw_in            = '0;
    raw_in[SCLK_IDX]  = sclk_in;
    raw_in[START_IDX] = conv_start_n;
  end

  cs_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(lvl));

  cs_edge #(.W(NSIG), .RST_VAL(IDLE_LVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall));

  assign sclk_rise  = rise[SCLK_IDX];
  assign sclk_fall  = fall[SCLK_IDX];
  assign start_rise = rise[START_IDX];
  assign start_fall = fall[START_IDX];
  assign start_lvl  = lvl[START_IDX];

  cs_frame_ctrl #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_lvl(start_lvl),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .start_rise(start_rise), .start_fall(start_fall),
    .sample(sample_in), .dout(sdata_out), .oe(sdata_oe),
    .ev_start(ev_start), .ev_release(ev_release), .ev_chain(ev_chain),
    .in_frame(in_frame), .rel_wait(rel_wait));
endmodule

// File: rtl/conv_result_shifter_chk.sv
`timescale 1ns/1ps
module conv_result_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic start_fall,
  input logic ev_start,
  input logic ev_release,
  input logic ev_chain,
  input logic in_frame,
  input logic rel_wait,
  input logic sdata_oe,
  input logic sdata_out
);
  // R2
  start_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (sdata_oe && !sdata_out));

  // R3
  dout_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !ev_start) |=> $stable(sdata_out));

  // R6
  release_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_wait && sclk_rise && !ev_start && !ev_chain) |=> !sdata_oe);

  // R8
  chain_keeps_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain |=> sdata_oe);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fall && in_frame && !ev_start && !sclk_fall) |=> in_frame);

  // R11
  oe_drop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> $past(ev_release));
endmodule

bind conv_result_shifter conv_result_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .start_fall(start_fall), .ev_start(ev_start), .ev_release(ev_release),
  .ev_chain(ev_chain), .in_frame(in_frame), .rel_wait(rel_wait),
  .sdata_oe(sdata_oe), .sdata_out(sdata_out));

// File: tb/sim_conv_result_shifter.sv
`timescale 1ns/1ps
module sim_conv_result_shifter;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n, sclk, start_n;
  logic [11:0] sample;
  logic sdo, soe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  conv_result_shifter u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .conv_start_n(start_n),
    .sample_in(sample), .sdata_out(sdo), .sdata_oe(soe));

  task automatic wph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bit(input logic [11:0] s, input int k);
    logic [15:0] f;
    f = {3'b000, s, 1'b0};
    return (k <= 15) ? int'(f[15-k]) : 0;
  endfunction

  task automatic start(input logic [11:0] s);
    sample = s; wph();
    start_n = 1'b0; wph();
    chk("R2 oe at start", int'(soe), 1);
    chk("R2 dout at start", int'(sdo), 0);
    sample = ~s;
  endtask

  // Serial clock idling low: rise then fall per bit.
  task automatic frame_lo(input logic [11:0] s, input int up_at, input int pulse_at,
                          output logic [11:0] w);
    w = '0;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b1; wph();
      chk("R3 bit", int'(sdo), exp_bit(s, k));
      if (k >= 3 && k <= 14) w[14-k] = sdo;
      if (k == up_at) begin start_n = 1'b1; wph(); end
      if (k == pulse_at) begin
        start_n = 1'b1; wph();
        sample = 12'h0F0; start_n = 1'b0; wph();
      end
      sclk = 1'b0; wph();
    end
  endtask

  // Serial clock idling high: fall then rise; stops after the 16th fall.
  task automatic frame_hi(input logic [11:0] s, output logic [11:0] w);
    w = '0;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; wph();
      if (k < 16) begin
        sclk = 1'b1; wph();
        chk("R3 bit idle-high", int'(sdo), exp_bit(s, k));
        if (k >= 3 && k <= 14) w[14-k] = sdo;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] s, w;
    rst_n = 1'b0; sclk = 1'b0; start_n = 1'b1; sample = '0;
    repeat (5) @(negedge clk);
    chk("R1 oe", int'(soe), 0);
    chk("R1 dout", int'(sdo), 0);
    rst_n = 1'b1; wph(); wph();

    // Sweep of samples, serial clock idling low.
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: s = 12'h7FF;
        1: s = 12'h800;
        2: s = 12'h000;
        3: s = 12'hFFF;
        default: s = 12'(i * 713) ^ 12'h5A3;
      endcase
      start(s);
      frame_lo(s, 0, 0, w);
      chk("R4 captured sample", int'(w), int'(s));
      if (i == 0) chk("R5 most positive", int'(w), int'(12'b0111_1111_1111));
      if (i == 1) chk("R5 most negative", int'(w), int'(12'b1000_0000_0000));
      chk("R6 oe held after last fall", int'(soe), 1);
      if (i % 2 == 0) begin
        sclk = 1'b1; wph();
        chk("R6 release on sclk rise", int'(soe), 0);
        sclk = 1'b0; wph();
        start_n = 1'b1; wph();
      end else begin
        start_n = 1'b1; wph();
        chk("R7 release on start rise", int'(soe), 0);
      end
    end

    // Chaining inside the window.
    start(12'h3C5);
    frame_lo(12'h3C5, 15, 0, w);
    chk("R8 first frame", int'(w), int'(12'h3C5));
    wph(); wph(); wph();
    chk("R8 oe kept", int'(soe), 1);
    chk("R8 dout low", int'(sdo), 0);
    start(12'hA5A);
    frame_lo(12'hA5A, 0, 0, w);
    chk("R8 chained frame", int'(w), int'(12'hA5A));
    start_n = 1'b1; wph();
    chk("R7 release after chain", int'(soe), 0);

    // Start high early: no window, drop at the 16th fall.
    start(12'h1E7);
    frame_lo(12'h1E7, 3, 0, w);
    chk("R11 oe dropped", int'(soe), 0);

    // Extra start pulse mid-frame is ignored.
    start_n = 1'b1; wph();
    start(12'h6B2);
    frame_lo(12'h6B2, 0, 5, w);
    chk("R9 original sample kept", int'(w), int'(12'h6B2));
    chk("R9 oe held", int'(soe), 1);
    start_n = 1'b1; wph();
    chk("R7 release", int'(soe), 0);

    // Serial clock idling high, release on the 16th rise.
    sclk = 1'b1; wph();
    start(12'h2D9);
    frame_hi(12'h2D9, w);
    chk("R2 idle-high frame", int'(w), int'(12'h2D9));
    chk("R6 oe held idle-high", int'(soe), 1);
    sclk = 1'b1; wph();
    chk("R6 release idle-high", int'(soe), 0);
    start_n = 1'b1; wph();

    // Chain and release rising together: chain wins.
    start(12'h4E1);
    frame_hi(12'h4E1, w);
    sclk = 1'b1; start_n = 1'b1; wph();
    chk("R10 oe kept", int'(soe), 1);
    chk("R10 dout low", int'(sdo), 0);
    start(12'hB37);
    frame_hi(12'hB37, w);
    chk("R10 next frame", int'(w), int'(12'hB37));
    sclk = 1'b1; wph();
    chk("R6 final release", int'(soe), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule